// File: doc/BRIEF.md
# Ping-Pong Block Pipeline Controller

This controller sequences a three-stage block pipeline. The stages fetch a block, transform it, and write it back, and all three can work on successive blocks at the same time. Two block-sized slots sit between the fetch stage and the transform stage, and two more sit between the transform stage and the write-back stage. The controller does not touch data. It decides when each stage's datapath may begin, tells that datapath which slot half to use, and frees slots as the datapath reports completion. Every hand-off works as a valid/ready pair: a stage may fill a slot only while the hand-off has room, and may drain one only while a filled slot waits.

A run begins with a start pulse that carries the block count and a mode bit. Both are captured for the whole run. With the mode bit high, each hand-off offers two slots. The fetch stage may then run one block ahead of the transform stage, and the steady-state block period becomes the slowest stage time rather than the sum of all three. With the mode bit low, each hand-off offers a single slot. Fetch and transform then never overlap, which gives plain block-by-block processing. A done flag rises once the last block has been written back.

A stage is *busy* from the clock edge that samples its start output until the edge that samples its done input. Start outputs are combinational one-cycle requests. A datapath's done pulse is one cycle wide.

Top module: `pingpong_ctrl`

## Requirements
- R1: After reset, no stage is busy, every start output is low, all four slot outputs are 0, and `run_busy` and `run_done` are low.
- R2: A `run_start` pulse while idle captures `blk_total` and `overlap_en` and then issues exactly `blk_total` starts to each stage. A `run_start` pulse during a run is ignored.
- R3: The k-th transform start occurs only after the k-th fetch done has been sampled. The k-th write-back start occurs only after the k-th transform done has been sampled.
- R4: In both modes, the k-th start of a stage (k from 0, counted per run) presents slot k mod 2. For fetch this is `ld_slot`; for transform it is `cp_in_slot` and `cp_out_slot`; for write-back it is `st_slot`.
- R5: With `overlap_en`=1, the k-th fetch start requires k − (transforms completed) < 2. The k-th transform start requires k − (write-backs completed) < 2, so transform never overwrites an undrained output slot.
- R6: With `overlap_en`=0, the same bounds are < 1. Fetch and transform are never busy in the same cycle, so consecutive write-back completions are at least Dl+Dc+2 cycles apart.
- R7: With `overlap_en`=1, the three stages can all be busy at once. For a datapath latency of D cycles per stage (start sampled to done sampled), the spacing of the last write-back completions in a long run is max(Dl,Dc,Ds)+1 cycles.
- R8: `run_done` rises in the cycle after the last write-back done is sampled and stays high until the next accepted `run_start`. With `blk_total`=0, it rises one cycle after the start, and no stage is started.
- R9: A done input that arrives while its stage is not busy has no effect on slots, starts or run status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_start | input | 1 | Starts a run when idle |
| blk_total | input | CNT_W | Number of blocks in the run |
| overlap_en | input | 1 | 1: two slots per hand-off, 0: one slot |
| run_busy | output | 1 | Run in progress |
| run_done | output | 1 | Last block written back |
| ld_start | output | 1 | Fetch datapath may begin a block |
| ld_slot | output | 1 | Input slot half being filled |
| ld_done | input | 1 | Fetch datapath finished its block |
| cp_start | output | 1 | Transform datapath may begin a block |
| cp_in_slot | output | 1 | Input slot half being read |
| cp_out_slot | output | 1 | Output slot half being written |
| cp_done | input | 1 | Transform datapath finished its block |
| st_start | output | 1 | Write-back datapath may begin a block |
| st_slot | output | 1 | Output slot half being drained |
| st_done | input | 1 | Write-back datapath finished its block |

## Verification
Wrong occupancy or pointer state appears at the ports within one block time. A leaked slot stalls the next start, so the run never reaches `run_done` and the block counts come up short. An extra free slot lets a start overtake its allowed look-ahead on the very cycle it is issued. A pointer that slips shows up as the wrong slot on the next start of that stage. A done counted while a stage is idle shifts the slot parity, or ends the run one block early.

// File: rtl/pingpong_ctrl.sv
module pingpong_ctrl #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_start,
  input  logic [CNT_W-1:0] blk_total,
  input  logic             overlap_en,
  output logic             run_busy,
  output logic             run_done,
  output logic             ld_start,
  output logic             ld_slot,
  input  logic             ld_done,
  output logic             cp_start,
  output logic             cp_in_slot,
  output logic             cp_out_slot,
  input  logic             cp_done,
  output logic             st_start,
  output logic             st_slot,
  input  logic             st_done
);

  logic [CNT_W-1:0] total_q, ld_cnt, cp_cnt, st_cnt;
  logic             ovl_q;
  logic             ld_busy, cp_busy, st_busy;
  logic [1:0]       in_occ, out_occ;
  logic             in_wptr, in_rptr, out_wptr, out_rptr;

  logic [1:0] cap;
  logic       in_ready, in_valid, out_ready, out_valid;
  logic       ld_fin, cp_fin, st_fin, last_st;

  assign cap       = ovl_q ? 2'd2 : 2'd1;
  assign in_ready  = in_occ < cap;
  assign in_valid  = in_occ != 2'd0;
  assign out_ready = out_occ < cap;
  assign out_valid = out_occ != 2'd0;

  assign ld_fin  = ld_busy & ld_done;
  assign cp_fin  = cp_busy & cp_done;
  assign st_fin  = st_busy & st_done;
  assign last_st = st_fin && (st_cnt == total_q - 1'b1);

  assign ld_start = run_busy & ~ld_busy & (ld_cnt != total_q) & in_ready;
  assign cp_start = run_busy & ~cp_busy & in_valid & out_ready;
  assign st_start = run_busy & ~st_busy & out_valid;

  assign ld_slot     = in_wptr;
  assign cp_in_slot  = in_rptr;
  assign cp_out_slot = out_wptr;
  assign st_slot     = out_rptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      total_q  <= '0;
      ovl_q    <= 1'b0;
      ld_cnt   <= '0;
      cp_cnt   <= '0;
      st_cnt   <= '0;
      ld_busy  <= 1'b0;
      cp_busy  <= 1'b0;
      st_busy  <= 1'b0;
      in_occ   <= 2'd0;
      out_occ  <= 2'd0;
      in_wptr  <= 1'b0;
      in_rptr  <= 1'b0;
      out_wptr <= 1'b0;
      out_rptr <= 1'b0;
      run_busy <= 1'b0;
      run_done <= 1'b0;
    end else if (run_start && !run_busy) begin
      total_q  <= blk_total;
      ovl_q    <= overlap_en;
      ld_cnt   <= '0;
      cp_cnt   <= '0;
      st_cnt   <= '0;
      in_wptr  <= 1'b0;
      in_rptr  <= 1'b0;
      out_wptr <= 1'b0;
      out_rptr <= 1'b0;
      run_busy <= blk_total != '0;
      run_done <= blk_total == '0;
    end else begin
      ld_busy  <= ld_start | (ld_busy & ~ld_done);
      cp_busy  <= cp_start | (cp_busy & ~cp_done);
      st_busy  <= st_start | (st_busy & ~st_done);
      ld_cnt   <= ld_cnt + {{(CNT_W-1){1'b0}}, ld_start};
      cp_cnt   <= cp_cnt + {{(CNT_W-1){1'b0}}, cp_start};
      st_cnt   <= st_cnt + {{(CNT_W-1){1'b0}}, st_fin};
      in_occ   <= in_occ + {1'b0, ld_fin} - {1'b0, cp_fin};
      out_occ  <= out_occ + {1'b0, cp_fin} - {1'b0, st_fin};
      in_wptr  <= in_wptr ^ ld_fin;
      in_rptr  <= in_rptr ^ cp_fin;
      out_wptr <= out_wptr ^ cp_fin;
      out_rptr <= out_rptr ^ st_fin;
      if (last_st) begin
        run_busy <= 1'b0;
        run_done <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pingpong_ctrl_chk.sv
module pingpong_ctrl_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_start,
  input logic             run_done,
  input logic             st_done,
  input logic             ovl_q,
  input logic             ld_busy,
  input logic             cp_busy,
  input logic [1:0]       in_occ,
  input logic [1:0]       out_occ,
  input logic             in_wptr,
  input logic             in_rptr,
  input logic             out_wptr,
  input logic             out_rptr,
  input logic [CNT_W-1:0] ld_cnt,
  input logic [CNT_W-1:0] cp_cnt
);

  p_in_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_occ <= (ovl_q ? 2'd2 : 2'd1));

  p_out_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_occ <= (ovl_q ? 2'd2 : 2'd1));

  p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ovl_q |-> !(ld_busy && cp_busy));

  p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cp_cnt <= ld_cnt);

  p_in_ptr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_occ == 2'd0) |-> (in_wptr == in_rptr));

  p_out_ptr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_occ == 2'd0) |-> (out_wptr == out_rptr));

  p_done_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_done) |-> $past(st_done || run_start));

endmodule

bind pingpong_ctrl pingpong_ctrl_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_pingpong_ctrl.sv
module test_pingpong_ctrl;
  localparam int CW = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, run_start = 1'b0, overlap_en = 1'b0;
  logic [CW-1:0] blk_total = '0;
  logic ld_done = 1'b0, cp_done = 1'b0, st_done = 1'b0;
  logic run_busy, run_done, ld_start, ld_slot, cp_start, cp_in_slot, cp_out_slot, st_start, st_slot;

  pingpong_ctrl #(.CNT_W(CW)) i_pingpong_ctrl (
    .clk(clk), .rst_n(rst_n), .run_start(run_start), .blk_total(blk_total),
    .overlap_en(overlap_en), .run_busy(run_busy), .run_done(run_done),
    .ld_start(ld_start), .ld_slot(ld_slot), .ld_done(ld_done),
    .cp_start(cp_start), .cp_in_slot(cp_in_slot), .cp_out_slot(cp_out_slot), .cp_done(cp_done),
    .st_start(st_start), .st_slot(st_slot), .st_done(st_done)
  );

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  bit mon_on = 0, all3 = 0;
  int dl, dc, ds, ntot, cap;
  int ld_st, cp_st, st_st, ld_dn, cp_dn, st_dn;
  int tl = 0, tc = 0, ts = 0, cyc = 0, last_sd, prev_sd;

  initial forever begin
    @(negedge clk);
    cyc++;
    if (mon_on) begin
      if (ld_start) begin
        chk(ld_slot == 1'(ld_st % 2), "R4 ld_slot", ld_slot, ld_st % 2);
        chk(ld_st - cp_dn < cap, cap == 2 ? "R5 fetch look-ahead" : "R6 fetch look-ahead", ld_st - cp_dn, cap - 1);
        chk(ld_st < ntot, "R2 fetch count", ld_st + 1, ntot);
        ld_st++;
      end
      if (cp_start) begin
        chk(cp_in_slot == 1'(cp_st % 2), "R4 cp_in_slot", cp_in_slot, cp_st % 2);
        chk(cp_out_slot == 1'(cp_st % 2), "R4 cp_out_slot", cp_out_slot, cp_st % 2);
        chk(cp_st < ld_dn, "R3 transform after fetch", cp_st, ld_dn - 1);
        chk(cp_st - st_dn < cap, cap == 2 ? "R5 output slot free" : "R6 output slot free", cp_st - st_dn, cap - 1);
        cp_st++;
      end
      if (st_start) begin
        chk(st_slot == 1'(st_st % 2), "R4 st_slot", st_slot, st_st % 2);
        chk(st_st < cp_dn, "R3 write-back after transform", st_st, cp_dn - 1);
        st_st++;
      end
      chk(run_done == (st_dn == ntot), "R8 run_done level", run_done, int'(st_dn == ntot));
      ld_done = 1'b0; cp_done = 1'b0; st_done = 1'b0;
      if (tl > 0) begin tl--; if (tl == 0) begin ld_done = 1'b1; ld_dn++; end end
      if (tc > 0) begin tc--; if (tc == 0) begin cp_done = 1'b1; cp_dn++; end end
      if (ts > 0) begin
        ts--;
        if (ts == 0) begin st_done = 1'b1; st_dn++; prev_sd = last_sd; last_sd = cyc; end
      end
      if (ld_start) tl = dl;
      if (cp_start) tc = dc;
      if (st_start) ts = ds;
      if (cap == 1) chk(!(tl > 0 && tc > 0), "R6 fetch/transform overlap", int'(tl > 0 && tc > 0), 0);
      if (tl > 0 && tc > 0 && ts > 0) all3 = 1;
    end
  end

  task automatic do_run(input int n, input bit ov, input int a, input int b, input int c, input bit poke);
    int mx;
    @(posedge clk); #1;
    ld_st = 0; cp_st = 0; st_st = 0; ld_dn = 0; cp_dn = 0; st_dn = 0;
    dl = a; dc = b; ds = c; ntot = n; cap = ov ? 2 : 1; all3 = 0;
    last_sd = -1; prev_sd = -1;
    blk_total = CW'(n); overlap_en = ov; run_start = 1'b1;
    @(posedge clk); #1;
    run_start = 1'b0; mon_on = 1;
    if (poke) begin
      repeat (6) @(posedge clk);
      #1 blk_total = CW'(1); overlap_en = 1'b0; run_start = 1'b1;
      @(posedge clk); #1 run_start = 1'b0;
    end
    for (int i = 0; i < 3000 && !run_done; i++) begin
      @(posedge clk); #1;
    end
    repeat (3) @(posedge clk);
    #1 mon_on = 0;
    chk(run_done == 1'b1, "R8 run_done held", run_done, 1);
    chk(run_busy == 1'b0, "R8 run_busy cleared", run_busy, 0);
    chk(ld_st == n, "R2 fetch starts", ld_st, n);
    chk(cp_st == n, "R2 transform starts", cp_st, n);
    chk(st_st == n, "R2 write-back starts", st_st, n);
    mx = a > b ? a : b;
    mx = mx > c ? mx : c;
    if (ov && n >= 3 && a == 1 && b == 1 && c == 1)
      chk(all3, "R7 three stages busy", all3, 1);
    if (n >= 4) begin
      if (ov) chk(last_sd - prev_sd == mx + 1, "R7 steady period", last_sd - prev_sd, mx + 1);
      else    chk(last_sd - prev_sd >= a + b + 2, "R6 sequential period", last_sd - prev_sd, a + b + 2);
    end
  endtask

  task automatic idle_dones(input string tag);
    logic s0, s1, s2, s3;
    @(posedge clk); #1;
    s0 = ld_slot; s1 = cp_in_slot; s2 = cp_out_slot; s3 = st_slot;
    ld_done = 1'b1; cp_done = 1'b1; st_done = 1'b1;
    @(posedge clk); #1;
    ld_done = 1'b0; cp_done = 1'b0; st_done = 1'b0;
    @(posedge clk); #1;
    chk(ld_slot == s0 && cp_in_slot == s1 && cp_out_slot == s2 && st_slot == s3,
        tag, {ld_slot, cp_in_slot, cp_out_slot, st_slot}, {s0, s1, s2, s3});
    chk(!ld_start && !cp_start && !st_start, tag, {ld_start, cp_start, st_start}, 0);
    chk(!run_busy, tag, run_busy, 0);
  endtask

  int nb[5] = '{0, 1, 2, 3, 5};
  int la[5] = '{1, 4, 1, 1, 2};
  int lb[5] = '{1, 1, 4, 1, 3};
  int lc[5] = '{1, 1, 1, 4, 5};

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    chk(!ld_start && !cp_start && !st_start, "R1 starts low", {ld_start, cp_start, st_start}, 0);
    chk({ld_slot, cp_in_slot, cp_out_slot, st_slot} == 4'b0, "R1 slots zero",
        {ld_slot, cp_in_slot, cp_out_slot, st_slot}, 0);
    chk(!run_busy && !run_done, "R1 run flags low", {run_busy, run_done}, 0);
    idle_dones("R9 done while idle after reset");
    chk(!run_done, "R9 run_done untouched", run_done, 0);
    for (int ov = 0; ov < 2; ov++)
      for (int ni = 0; ni < 5; ni++)
        for (int li = 0; li < 5; li++)
          do_run(nb[ni], ov[0], la[li], lb[li], lc[li], 1'b0);
    do_run(5, 1'b1, 2, 3, 5, 1'b1);
    do_run(5, 1'b1, 1, 1, 1, 1'b0);
    idle_dones("R9 done while idle after run");
    chk(run_done, "R9 run_done kept", run_done, 1);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule